// File: doc/BRIEF.md
# Register-Driven Byte SPI Master

This block is a serial peripheral interface master that a processor runs through two 32-bit memory-mapped words: a control/status word and a data word. Software places a byte in the data word, then writes the control word with the start bit set. The block shifts that byte out on the serial data output and shifts a byte in from the serial data input at the same time. When the busy flag drops, software reads the received byte back from the data word.

The same control word sets several other things. It holds the levels of three chip-select outputs. It holds a five-bit divider that sets the serial clock rate from the block's own clock. It also holds a bit that routes the outgoing serial stream straight back into the receiver, for testing without a slave attached. Every control write updates these settings, whether or not it starts a transfer. The serial protocol is mode 0: the clock idles low, data is sampled on the rising edge, data changes on the falling edge, and the most significant bit goes first.

Top module: `spi_byte_master`

## Requirements
- R1: The control word is at byte offset 0x0 and the data word is at byte offset 0x4. Any other offset reads as zero, and writes to it change nothing.
- R2: After reset, the control word reads 0x0000_0015, the data word reads zero, the serial clock is low and all three chip-select outputs are high.
- R3: Every control write loads the following fields, whether or not bit 1 is set: chip-select output n (n = 0, 1, 2) from control bit 2n, the divider D from bits 31:27, and loopback from bit 3. All of them read back at the same positions.
- R4: A control write with bit 1 set while idle starts one 8-bit transfer. Control bit 1 reads as 1 (busy) from the cycle after that write for exactly 16·(D+1) clock cycles.
- R5: During a transfer the serial clock gives exactly 8 rising edges, spaced 2·(D+1) clock cycles apart, and it is low whenever the block is idle.
- R6: The transmitted byte is the data word as it was at start, sent most significant bit first. The serial data output changes only on a falling serial-clock edge, except for presenting the first bit when the transfer starts.
- R7: The serial data input is sampled on each rising serial-clock edge, most significant bit first. After busy clears, the data word reads the received byte in bits 7:0 and zero in bits 31:8.
- R8: With loopback (control bit 3) set, the received byte equals the transmitted byte and the serial data input is ignored.
- R9: A start written while busy is ignored: the running transfer keeps its original length and data. The other control fields of that write still take effect at once.
- R10: While busy, a read of the data word returns the byte received by the previous transfer.
- R11: Control bits 26:5 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select levels, straight from the control bits |

## Verification
The bench sweeps the divider over its low values and also runs the maximum value. It uses several byte patterns, with and without loopback. For each transfer it measures the busy length, the serial clock spacing, the captured output stream and the received byte. An off-by-one in the half-period counter would show up as a wrong busy count and wrong edge spacing. Reversed bit order, or sampling on the wrong edge, would corrupt the received or captured byte. A loopback path that still listened to the input pin would return the slave's byte instead of the transmitted one. A second start during a transfer must not stretch the busy time, yet its new chip-select levels must appear at once. Reads of unused offsets and reserved bits must come back as zero.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [2:0]        spi_cs
);
  localparam int NCS      = 3;
  localparam int BITS     = 8;
  localparam int CNT_W    = $clog2(BITS) + 1;
  localparam int DIV_LSB  = 32 - DIV_W;
  localparam int PAD_W    = DIV_LSB - 5;
  localparam int GO_BIT   = 1;
  localparam int LOOP_BIT = 3;
  localparam logic [ADDR_W-1:0] CTRL_OFS = '0;
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(4);

  logic [DIV_W-1:0] div_q, tick_q;
  logic [NCS-1:0]   cs_q;
  logic             loop_q, busy_q, sck_q;
  logic [BITS-1:0]  tx_q, txsh_q, rxsh_q, rx_q;
  logic [CNT_W-1:0] nbit_q;

  logic ctrl_wr, data_wr, go, half_done, rx_in;
  logic unused_wbits;

  assign ctrl_wr      = bus_en & bus_we & (bus_addr == CTRL_OFS);
  assign data_wr      = bus_en & bus_we & (bus_addr == DATA_OFS);
  assign go           = ctrl_wr & bus_wdata[GO_BIT] & ~busy_q;
  assign half_done    = (tick_q >= div_q);
  assign rx_in        = loop_q ? txsh_q[BITS-1] : spi_miso;
  assign unused_wbits = ^bus_wdata[DIV_LSB-1:BITS];

  assign spi_sck  = sck_q;
  assign spi_mosi = txsh_q[BITS-1];
  assign spi_cs   = cs_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (bus_addr == CTRL_OFS)
        bus_rdata = {div_q, {PAD_W{1'b0}}, cs_q[2], loop_q, cs_q[1], busy_q, cs_q[0]};
      else if (bus_addr == DATA_OFS)
        bus_rdata = {{(32-BITS){1'b0}}, rx_q};
    end
  end

  for (genvar n = 0; n < NCS; n++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cs_q[n] <= 1'b1;
      else if (ctrl_wr) cs_q[n] <= bus_wdata[2*n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= '0;
      loop_q <= 1'b0;
    end else if (ctrl_wr) begin
      div_q  <= bus_wdata[31:DIV_LSB];
      loop_q <= bus_wdata[LOOP_BIT];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tx_q <= '0;
    else if (data_wr) tx_q <= bus_wdata[BITS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      tick_q <= '0;
      nbit_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      rx_q   <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      tick_q <= '0;
      nbit_q <= '0;
      txsh_q <= tx_q;
    end else if (busy_q) begin
      if (!half_done) begin
        tick_q <= tick_q + 1'b1;
      end else begin
        tick_q <= '0;
        if (!sck_q) begin
          sck_q  <= 1'b1;
          rxsh_q <= {rxsh_q[BITS-2:0], rx_in};
          nbit_q <= nbit_q + 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (nbit_q == CNT_W'(BITS)) begin
            busy_q <= 1'b0;
            rx_q   <= rxsh_q;
          end else begin
            txsh_q <= {txsh_q[BITS-2:0], 1'b0};
          end
        end
      end
    end

  assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(ctrl_wr && bus_wdata[GO_BIT]));
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !spi_sck);
  assert_mosi_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(spi_mosi)) |-> $fell(spi_sck));
  assert_cs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_wr) |-> $stable(spi_cs));
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(rx_q));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (nbit_q >= $past(nbit_q)));
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sck, spi_mosi, spi_miso;
  logic [2:0] spi_cs;

  int total = 0, bad = 0, cyc = 0, rises = 0, last_rise = 0, cur_d = 0;
  logic [7:0] slave = '0, mosi_cap = '0, last_rx = '0;

  always #10 clk = ~clk;

  spi_byte_master u0 (.clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .spi_sck, .spi_mosi, .spi_miso, .spi_cs);

  assign spi_miso = (rises < 8) ? slave[7-rises] : 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge spi_sck) begin
    if (rises > 0) chk(cyc - last_rise == 2*(cur_d+1), "R5 sck spacing", cyc - last_rise, 2*(cur_d+1));
    last_rise = cyc;
    mosi_cap = {mosi_cap[6:0], spi_mosi};
    rises++;
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic poll(output int n);
    logic [31:0] v, dv;
    n = 0;
    forever begin
      bus_read(4'h0, v);
      if (!v[1] || n > 4000) break;
      n++;
      if (n == 2) begin
        bus_read(4'h4, dv);
        chk(dv == {24'h0, last_rx}, "R10 data during busy", dv, {24'h0, last_rx});
      end
      @(negedge clk);
    end
  endtask

  task automatic xfer(input int d, input logic [7:0] tx, input logic [7:0] sl, input bit lb);
    int n;
    logic [31:0] v;
    logic [7:0] exp;
    bus_write(4'h4, {24'h0, tx});
    slave = sl; rises = 0; cur_d = d; mosi_cap = '0;
    bus_write(4'h0, (32'(d) << 27) | 32'h15 | (32'(lb) << 3) | 32'h2);
    poll(n);
    chk(n == 16*(d+1), "R4 busy length", n, 16*(d+1));
    chk(rises == 8, "R5 edge count", rises, 8);
    chk(mosi_cap == tx, "R6 mosi byte", mosi_cap, tx);
    exp = lb ? tx : sl;
    bus_read(4'h4, v);
    chk(v == {24'h0, exp}, lb ? "R8 loopback rx" : "R7 rx byte", v, {24'h0, exp});
    chk(spi_cs == 3'b111, "R3 cs levels", spi_cs, 3'b111);
    last_rx = exp;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(4'h0, v); chk(v == 32'h15, "R2 ctrl reset", v, 32'h15);
    bus_read(4'h4, v); chk(v == 32'h0, "R2 data reset", v, 0);
    chk(spi_sck == 1'b0, "R2 sck idle", spi_sck, 0);
    chk(spi_cs == 3'b111, "R2 cs high", spi_cs, 3'b111);

    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++)
        for (int lb = 0; lb < 2; lb++)
          xfer(d, 8'h5A ^ 8'(p * 8'h3C) ^ 8'(d), 8'hA7 ^ 8'(p * 8'h29), lb[0]);
    xfer(31, 8'h81, 8'h7E, 1'b0);

    bus_write(4'h4, 32'hC3);
    slave = 8'h96; rises = 0; cur_d = 1; mosi_cap = '0;
    bus_write(4'h0, (32'd1 << 27) | 32'h17);
    bus_write(4'h0, (32'd1 << 27) | 32'h02);
    chk(spi_cs == 3'b000, "R9 cs updates while busy", spi_cs, 0);
    poll(n);
    chk(n == 31, "R9 busy not stretched", n, 31);
    chk(mosi_cap == 8'hC3, "R9 data kept", mosi_cap, 8'hC3);
    bus_read(4'h4, v); chk(v == 32'h96, "R9 rx kept", v, 32'h96);
    bus_read(4'h0, v); chk(v == 32'h0800_0000, "R3 ctrl readback", v, 32'h0800_0000);

    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h0, v); chk(v == 32'h0800_0000, "R1 stray write ignored", v, 32'h0800_0000);
    bus_read(4'h8, v); chk(v == 32'h0, "R1 offset 8 reads zero", v, 0);
    bus_read(4'hC, v); chk(v == 32'h0, "R1 offset C reads zero", v, 0);
    bus_read(4'h4, v); chk(v == 32'h96, "R1 data unchanged", v, 32'h96);

    bus_write(4'h0, 32'hFFFF_FFFD);
    bus_read(4'h0, v); chk(v == 32'hF800_001D, "R11 reserved bits zero", v, 32'hF800_001D);
    chk(spi_cs == 3'b111, "R3 cs from bits 0 2 4", spi_cs, 3'b111);
    bus_write(4'h0, 32'h0000_0004);
    chk(spi_cs == 3'b010, "R3 cs1 only", spi_cs, 3'b010);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule